// File: doc/BRIEF.md
# Reference Clock Bring-Up Sequencer

This block starts the reference clock of one port in a multi-port PCIe root complex. On a start pulse it acts as the only master on a simple memory-mapped register bus and works through a fixed list of steps. Each step is either a read-modify-write that sets or clears bits in one register, or a poll that waits for one status bit. Before any reference-clock step it turns on the port's application clock. It then waits for the reference clock to be present, opens the lane configuration window, and runs a request/acknowledge exchange on the first clock request. After that it enables the second clock and waits to read it back, closes the window, and only then sets the clock-enable pair and the port's reference-clock enable.

If the caller asks for it, the sequencer then takes the port out of reset and waits for the port to report ready. A microsecond tick paces the polls. Every wait has its own timeout. The run ends in a done state or in an error state that records which step failed. Both outcomes are held until the next start.

Top module: `refclk_bringup_seq`

## Requirements
- R1: After a synchronous reset, busy, done and error are low and no bus request is raised.
- R2: A start pulse is accepted only while busy is low, and it latches the port index and the reset-release option. A start pulse while busy is ignored, and the running sequence keeps its original port.
- R3: busy rises in the cycle after an accepted start. It stays high without a gap until done or error rises, and no bus request is raised while busy is low.
- R4: The writes go out in this order:
  - application clock enable: bit 0 at port base + 0x800
  - window open: bit 15 at lane control, core base + 0x84004 + 0x4000·port
  - first clock request: bit 0 at lane config, core base + 0x84000 + 0x4000·port
  - second clock: bit 1 at lane config
  - window close: bit 15 cleared at lane control
  - clock-enable pair: bits 9 and 10 at lane config
  - reference clock enable: bit 0 at port base + 0x810
  - reset release (optional): bit 0 at port base + 0x814

  Here port base is PORT_BASE + PORT_STRIDE·port. No other address is written.
- R5: Every write is a read-modify-write of the same address. It changes only the named bits and writes back all other bits exactly as they were read.
- R6: The sequence holds at four waits, each until its bit reads as 1:
  - bit 4 of the core status word at core base + 0x28
  - bit 2 of lane config, after the first clock request
  - bit 1 of lane config, after the second clock write
  - bit 0 of the port status word at port base + 0x804, after reset release

  A bit that appears late, but before the timeout, lets the sequence continue.
- R7: A failed poll is repeated after POLL_US ticks. When a poll fails and at least the wait's limit of ticks has passed since the wait began, the sequencer stops with error high. The limit is REF_TMO_US for the three clock waits and RDY_TMO_US for the ready wait. err_step then holds the failing step code: 1 for clock presence, 4 for the request acknowledge, 6 for the second clock, 11 for port ready.
- R8: With the reset-release option off, done follows the reference clock enable write. There is no write at port base + 0x814 and no read of port status.
- R9: done and error are never high together. done, error and err_step hold their values until the next accepted start, which clears them.
- R10: While a bus request waits for its acknowledge, the address, the write flag and the write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when not busy |
| port_sel | input | PORT_W | Port index to bring up |
| perst_release | input | 1 | Also release port reset and wait for ready |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid with it |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence completed, held |
| error | output | 1 | A wait timed out, held |
| err_step | output | 4 | Code of the step that timed out |

## Verification
A wrong step counter or a wrong descriptor decode shows up at once on the bus. It appears as a write to the wrong address, or with wrong data, in the very next access, so the bench compares the whole write trace of every run against a list it builds from the requirements. A timer or gap fault changes when error rises compared with the tick count, or lets a wait finish early. Each timeout case therefore checks the error time against the wait's limit in ticks, and it also checks the step code. A fault in the state kept between runs shows as done or error that does not hold, or that does not clear on the next start, within a few cycles.

// File: rtl/refclk_seq_pkg.sv
package refclk_seq_pkg;

  localparam int DATA_W = 32;

  // Register offsets
  localparam logic [31:0] PHY_STAT_OFS = 32'h0000_0028;
  localparam logic [31:0] LANE_CFG_OFS = 32'h0008_4000;
  localparam logic [31:0] LANE_CTL_OFS = 32'h0008_4004;
  localparam logic [31:0] APPCLK_OFS   = 32'h0000_0800;
  localparam logic [31:0] PSTAT_OFS    = 32'h0000_0804;
  localparam logic [31:0] PREF_OFS     = 32'h0000_0810;
  localparam logic [31:0] PERST_OFS    = 32'h0000_0814;

  // Bit masks
  localparam logic [31:0] PHY_REFCLK_M = 32'h0000_0010;
  localparam logic [31:0] WIN_M        = 32'h0000_8000;
  localparam logic [31:0] REQ0_M       = 32'h0000_0001;
  localparam logic [31:0] CLK1_M       = 32'h0000_0002;
  localparam logic [31:0] ACK0_M       = 32'h0000_0004;
  localparam logic [31:0] CLKEN_M      = 32'h0000_0600;
  localparam logic [31:0] APPCLK_EN_M  = 32'h0000_0001;
  localparam logic [31:0] PREADY_M     = 32'h0000_0001;
  localparam logic [31:0] PREF_EN_M    = 32'h0000_0001;
  localparam logic [31:0] PERST_OFF_M  = 32'h0000_0001;

  typedef enum logic [3:0] {
    STP_APPCLK     = 4'd0,
    STP_PHY_WAIT   = 4'd1,
    STP_WIN_OPEN   = 4'd2,
    STP_REQ0       = 4'd3,
    STP_ACK0_WAIT  = 4'd4,
    STP_CLK1_SET   = 4'd5,
    STP_CLK1_WAIT  = 4'd6,
    STP_WIN_CLOSE  = 4'd7,
    STP_CLK_EN     = 4'd8,
    STP_PORT_REF   = 4'd9,
    STP_PERST      = 4'd10,
    STP_READY_WAIT = 4'd11
  } step_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_OP    = 2'd2,
    SQ_GAP   = 2'd3
  } seq_e;

  function automatic logic is_poll_step(input step_e s);
    return (s == STP_PHY_WAIT) || (s == STP_ACK0_WAIT) ||
           (s == STP_CLK1_WAIT) || (s == STP_READY_WAIT);
  endfunction

endpackage

// File: rtl/refclk_rmw_engine.sv
module refclk_rmw_engine
  import refclk_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_go,
  input  logic              op_rmw,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_set,
  input  logic [DATA_W-1:0] op_clr,
  output logic              op_done,
  output logic [DATA_W-1:0] op_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_e;

  eng_e              est;
  logic              rmw_q;
  logic [DATA_W-1:0] set_q;
  logic [DATA_W-1:0] clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      est       <= E_IDLE;
      rmw_q     <= 1'b0;
      set_q     <= '0;
      clr_q     <= '0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      op_done <= 1'b0;
      case (est)
        E_IDLE: begin
          if (op_go) begin
            rmw_q    <= op_rmw;
            set_q    <= op_set;
            clr_q    <= op_clr;
            bus_addr <= op_addr;
            bus_we   <= 1'b0;
            bus_req  <= 1'b1;
            est      <= E_RD;
          end
        end
        E_RD: begin
          if (bus_ack) begin
            op_rdata <= bus_rdata;
            if (rmw_q) begin
              bus_we    <= 1'b1;
              bus_wdata <= (bus_rdata | set_q) & ~clr_q;
              est       <= E_WR;
            end else begin
              bus_req <= 1'b0;
              op_done <= 1'b1;
              est     <= E_IDLE;
            end
          end
        end
        E_WR: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            op_done <= 1'b1;
            est     <= E_IDLE;
          end
        end
        default: est <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refclk_tick_timer.sv
module refclk_tick_timer #(
  parameter int POLL_US = 100,
  parameter int LIM_W   = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             gap_arm,
  input  logic             us_tick,
  input  logic [LIM_W-1:0] limit,
  output logic             gap_over,
  output logic             expired
);

  localparam int GAP_W = $clog2(POLL_US + 1);

  logic [GAP_W-1:0] gap_cnt;
  logic [LIM_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
      gap_cnt <= '0;
    end else begin
      if (us_tick && (elapsed != '1))
        elapsed <= elapsed + 1'b1;
      if (gap_arm)
        gap_cnt <= '0;
      else if (us_tick && (gap_cnt < GAP_W'(POLL_US)))
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign gap_over = (gap_cnt >= GAP_W'(POLL_US));
  assign expired  = (elapsed >= limit);

endmodule

// File: rtl/refclk_bringup_seq.sv
module refclk_bringup_seq
  import refclk_seq_pkg::*;
#(
  parameter int                N_PORTS     = 4,
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] CORE_BASE   = '0,
  parameter logic [ADDR_W-1:0] PORT_BASE   = ADDR_W'(32'h0010_0000),
  parameter logic [ADDR_W-1:0] PORT_STRIDE = ADDR_W'(32'h0000_8000),
  parameter logic [ADDR_W-1:0] LANE_STRIDE = ADDR_W'(32'h0000_4000),
  parameter int                POLL_US     = 100,
  parameter int                REF_TMO_US  = 50000,
  parameter int                RDY_TMO_US  = 250000,
  localparam int               PORT_W      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PORT_W-1:0] port_sel,
  input  logic              perst_release,
  input  logic              us_tick,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [3:0]        err_step
);

  localparam int TMO_MAX = (REF_TMO_US > RDY_TMO_US) ? REF_TMO_US : RDY_TMO_US;
  localparam int LIM_W   = $clog2(TMO_MAX + 1);

  seq_e              st;
  step_e             step;
  logic [PORT_W-1:0] port_q;
  logic              perst_q;

  // Step descriptor
  logic [ADDR_W-1:0] lane_cfg_a, lane_ctl_a, port_a;
  logic [ADDR_W-1:0] d_addr;
  logic              d_rmw;
  logic [DATA_W-1:0] d_set, d_clr, d_chk;

  // Engine / timer links
  logic              op_go, op_done;
  logic [DATA_W-1:0] op_rdata;
  logic              gap_over, expired, tmr_restart, gap_arm;
  logic [LIM_W-1:0]  limit;

  // Step outcome
  logic              op_end, poll_ok, step_pass, last_step;
  step_e             nxt_step;

  assign lane_cfg_a = CORE_BASE + ADDR_W'(LANE_CFG_OFS) + ADDR_W'(port_q) * LANE_STRIDE;
  assign lane_ctl_a = CORE_BASE + ADDR_W'(LANE_CTL_OFS) + ADDR_W'(port_q) * LANE_STRIDE;
  assign port_a     = PORT_BASE + ADDR_W'(port_q) * PORT_STRIDE;

  always_comb begin
    d_addr = lane_cfg_a;
    d_rmw  = 1'b1;
    d_set  = '0;
    d_clr  = '0;
    d_chk  = '0;
    case (step)
      STP_APPCLK: begin
        d_addr = port_a + ADDR_W'(APPCLK_OFS);
        d_set  = APPCLK_EN_M;
      end
      STP_PHY_WAIT: begin
        d_addr = CORE_BASE + ADDR_W'(PHY_STAT_OFS);
        d_rmw  = 1'b0;
        d_chk  = PHY_REFCLK_M;
      end
      STP_WIN_OPEN: begin
        d_addr = lane_ctl_a;
        d_set  = WIN_M;
      end
      STP_REQ0:      d_set = REQ0_M;
      STP_ACK0_WAIT: begin
        d_rmw = 1'b0;
        d_chk = ACK0_M;
      end
      STP_CLK1_SET:  d_set = CLK1_M;
      STP_CLK1_WAIT: begin
        d_rmw = 1'b0;
        d_chk = CLK1_M;
      end
      STP_WIN_CLOSE: begin
        d_addr = lane_ctl_a;
        d_clr  = WIN_M;
      end
      STP_CLK_EN:    d_set = CLKEN_M;
      STP_PORT_REF: begin
        d_addr = port_a + ADDR_W'(PREF_OFS);
        d_set  = PREF_EN_M;
      end
      STP_PERST: begin
        d_addr = port_a + ADDR_W'(PERST_OFS);
        d_set  = PERST_OFF_M;
      end
      STP_READY_WAIT: begin
        d_addr = port_a + ADDR_W'(PSTAT_OFS);
        d_rmw  = 1'b0;
        d_chk  = PREADY_M;
      end
      default: ;
    endcase
  end

  assign op_go     = (st == SQ_ISSUE);
  assign op_end    = (st == SQ_OP) && op_done;
  assign poll_ok   = ((op_rdata & d_chk) == d_chk);
  assign step_pass = d_rmw || poll_ok;
  assign last_step = (step == STP_READY_WAIT) || ((step == STP_PORT_REF) && !perst_q);
  assign nxt_step  = step_e'(4'(step) + 4'd1);

  assign tmr_restart = op_end && step_pass && !last_step && is_poll_step(nxt_step);
  assign gap_arm     = op_end && !step_pass && !expired;
  assign limit       = (step == STP_READY_WAIT) ? LIM_W'(RDY_TMO_US) : LIM_W'(REF_TMO_US);

  refclk_rmw_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .op_go     (op_go),
    .op_rmw    (d_rmw),
    .op_addr   (d_addr),
    .op_set    (d_set),
    .op_clr    (d_clr),
    .op_done   (op_done),
    .op_rdata  (op_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
  );

  refclk_tick_timer #(.POLL_US(POLL_US), .LIM_W(LIM_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .restart  (tmr_restart),
    .gap_arm  (gap_arm),
    .us_tick  (us_tick),
    .limit    (limit),
    .gap_over (gap_over),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      step     <= STP_APPCLK;
      port_q   <= '0;
      perst_q  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      err_step <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start) begin
            port_q   <= port_sel;
            perst_q  <= perst_release;
            step     <= STP_APPCLK;
            busy     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
            err_step <= '0;
            st       <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: st <= SQ_OP;
        SQ_OP: begin
          if (op_done) begin
            if (step_pass) begin
              if (last_step) begin
                busy <= 1'b0;
                done <= 1'b1;
                st   <= SQ_IDLE;
              end else begin
                step <= nxt_step;
                st   <= SQ_ISSUE;
              end
            end else if (expired) begin
              busy     <= 1'b0;
              error    <= 1'b1;
              err_step <= 4'(step);
              st       <= SQ_IDLE;
            end else begin
              st <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (gap_over)
            st <= SQ_ISSUE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refclk_bringup_chk.sv
module refclk_bringup_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [3:0]        err_step,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy && !done && !error && !bus_req); // R1

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    !busy && start |=> busy); // R2

  AST_BUSY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done && !error); // R3

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req); // R3

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R9

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    error && !start |=> error && $stable(err_step)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                             && $stable(bus_wdata)); // R10

endmodule

bind refclk_bringup_seq refclk_bringup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .err_step  (err_step),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack)
);

// File: tb/refclk_bringup_seq_tb.sv
module refclk_bringup_seq_tb;

  localparam int          NP      = 2;
  localparam int          POLL    = 2;
  localparam int          REF_TMO = 12;
  localparam int          RDY_TMO = 24;
  localparam logic [31:0] PBASE   = 32'h0010_0000;
  localparam logic [31:0] PSTRIDE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [0:0]  port_sel = '0;
  logic        perst_release = 1'b0;
  logic        us_tick = 1'b0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        busy, done, error;
  logic [3:0]  err_step;

  always #5 clk = ~clk;

  refclk_bringup_seq #(
    .N_PORTS(NP), .ADDR_W(32), .CORE_BASE(32'h0), .PORT_BASE(PBASE),
    .PORT_STRIDE(PSTRIDE), .LANE_STRIDE(32'h4000), .POLL_US(POLL),
    .REF_TMO_US(REF_TMO), .RDY_TMO_US(RDY_TMO)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .port_sel(port_sel),
    .perst_release(perst_release), .us_tick(us_tick),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .error(error), .err_step(err_step)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, tick_cnt = 0, tdiv = 0;
  int t_start = 0, t_req0 = 0, t_perst = 0;
  int k_phy = 0, k_ack = 0, k_rdy = 0, k_lat = 0, lat_left = 0;
  bit k_stuck = 0;
  int n_stat_rd = 0, n_stray = 0, n_hold_err = 0, lg_n = 0;
  logic [31:0] lg_a [32];
  logic [31:0] lg_d [32];
  logic [31:0] m_cfg [NP];
  logic [31:0] m_ctl [NP];
  logic [31:0] m_app [NP];
  logic [31:0] m_ref [NP];
  logic [31:0] m_per [NP];
  logic [31:0] m_pst [NP];
  bit          held = 0;
  logic [31:0] h_a, h_d;
  logic        h_we;

  function automatic logic [31:0] junk(int k, int p);
    return 32'h5A00_0100 | (32'(k) << 16) | (32'(p) << 20);
  endfunction
  function automatic logic [31:0] a_cfg(int p); return 32'h84000 + 32'(p) * 32'h4000; endfunction
  function automatic logic [31:0] a_ctl(int p); return a_cfg(p) + 32'h4; endfunction
  function automatic logic [31:0] a_prt(int p); return PBASE + 32'(p) * PSTRIDE; endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // microsecond tick: one clock in four
  always @(negedge clk) begin
    cyc++;
    if (tdiv == 3) begin tdiv = 0; us_tick = 1'b1; tick_cnt++; end
    else begin tdiv++; us_tick = 1'b0; end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic do_read(input logic [31:0] a, output logic [31:0] v);
    bit hit = 0;
    v = '0;
    if (a == 32'h28) begin
      hit = 1;
      v = 32'h0100_0001;
      if (k_phy >= 0 && tick_cnt - t_start >= k_phy) v |= 32'h10;
    end
    for (int p = 0; p < NP; p++) begin
      if (a == a_cfg(p)) begin
        hit = 1; v = m_cfg[p];
        if (m_cfg[p][0] && k_ack >= 0 && tick_cnt - t_req0 >= k_ack) v |= 32'h4;
      end
      if (a == a_ctl(p)) begin hit = 1; v = m_ctl[p]; end
      if (a == a_prt(p) + 32'h800) begin hit = 1; v = m_app[p]; end
      if (a == a_prt(p) + 32'h810) begin hit = 1; v = m_ref[p]; end
      if (a == a_prt(p) + 32'h814) begin hit = 1; v = m_per[p]; end
      if (a == a_prt(p) + 32'h804) begin
        hit = 1; n_stat_rd++; v = m_pst[p];
        if (m_per[p][0] && k_rdy >= 0 && tick_cnt - t_perst >= k_rdy) v |= 32'h1;
      end
    end
    if (!hit) n_stray++;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    bit hit = 0;
    if (lg_n < 32) begin lg_a[lg_n] = a; lg_d[lg_n] = d; end
    lg_n++;
    for (int p = 0; p < NP; p++) begin
      if (a == a_cfg(p)) begin
        hit = 1;
        if (d[0] && !m_cfg[p][0]) t_req0 = tick_cnt;
        m_cfg[p] = k_stuck ? (d & ~32'h2) : d;
      end
      if (a == a_ctl(p)) begin hit = 1; m_ctl[p] = d; end
      if (a == a_prt(p) + 32'h800) begin hit = 1; m_app[p] = d; end
      if (a == a_prt(p) + 32'h810) begin hit = 1; m_ref[p] = d; end
      if (a == a_prt(p) + 32'h814) begin
        hit = 1;
        if (d[0] && !m_per[p][0]) t_perst = tick_cnt;
        m_per[p] = d;
      end
    end
    if (!hit) n_stray++;
  endtask

  // bus responder
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0; held = 0; lat_left = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0; held = 0;
    end else if (bus_req) begin
      if (held && (bus_addr != h_a || bus_we != h_we || (bus_we && bus_wdata != h_d)))
        n_hold_err++;
      if (lat_left > 0) begin
        lat_left--; held = 1; h_a = bus_addr; h_we = bus_we; h_d = bus_wdata;
      end else begin
        if (bus_we) do_write(bus_addr, bus_wdata);
        else do_read(bus_addr, bus_rdata);
        bus_ack = 1'b1; held = 0; lat_left = k_lat;
      end
    end
  end

  task automatic reset_model();
    for (int p = 0; p < NP; p++) begin
      m_app[p] = junk(0, p); m_ctl[p] = junk(1, p); m_cfg[p] = junk(2, p);
      m_ref[p] = junk(3, p); m_per[p] = junk(4, p); m_pst[p] = junk(5, p);
    end
    lg_n = 0; n_stat_rd = 0; n_stray = 0;
  endtask

  task automatic launch(int p, bit pe);
    reset_model();
    @(negedge clk);
    port_sel = 1'(p); perst_release = pe; start = 1'b1; t_start = tick_cnt;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !error, "R2", "busy after start", {29'b0, busy, done, error}, 32'h4);
  endtask

  task automatic finish_wait(output bit gap);
    int n = 0;
    gap = 0;
    while (!(done || error) && n < 20000) begin
      @(negedge clk); n++;
      if (!busy && !done && !error) gap = 1;
    end
    check(done || error, "R3", "run ends", {31'b0, done | error}, 32'h1);
  endtask

  task automatic exp_writes(int p, bit pe);
    logic [31:0] ea [8];
    logic [31:0] ed [8];
    int n = pe ? 8 : 7;
    ea[0] = a_prt(p) + 32'h800; ed[0] = junk(0, p) | 32'h1;
    ea[1] = a_ctl(p);           ed[1] = junk(1, p) | 32'h8000;
    ea[2] = a_cfg(p);           ed[2] = junk(2, p) | 32'h1;
    ea[3] = a_cfg(p);           ed[3] = junk(2, p) | 32'h7;
    ea[4] = a_ctl(p);           ed[4] = junk(1, p);
    ea[5] = a_cfg(p);           ed[5] = junk(2, p) | 32'h607;
    ea[6] = a_prt(p) + 32'h810; ed[6] = junk(3, p) | 32'h1;
    ea[7] = a_prt(p) + 32'h814; ed[7] = junk(4, p) | 32'h1;
    check(lg_n == n, "R4", "write count", 32'(lg_n), 32'(n));
    for (int i = 0; i < n && i < lg_n; i++) begin
      check(lg_a[i] == ea[i], "R4", "write address", lg_a[i], ea[i]);
      check(lg_d[i] == ed[i], "R5", "write data", lg_d[i], ed[i]);
    end
    check(n_stray == 0, "R4", "stray accesses", 32'(n_stray), 32'h0);
  endtask

  task automatic timeout_case(int p, bit pe, int exp_step, int lim);
    bit gap;
    int dt;
    launch(p, pe);
    finish_wait(gap);
    dt = tick_cnt - t_start;
    check(error && !done, "R7", "error set", {30'b0, error, done}, 32'h2);
    check(err_step == 4'(exp_step), "R7", "err_step", 32'(err_step), 32'(exp_step));
    check(dt >= lim, "R7", "not before limit", 32'(dt), 32'(lim));
    check(dt <= lim + POLL + 24, "R7", "soon after limit", 32'(dt), 32'(lim + POLL + 24));
  endtask

  initial begin
    bit gap;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !error && !bus_req, "R1", "reset state",
          {28'b0, busy, done, error, bus_req}, 32'h0);

    // sweep of ports, reset-release option, bus latency and late status bits
    for (int p = 0; p < NP; p++)
      for (int pe = 0; pe < 2; pe++)
        for (int lt = 0; lt < 2; lt++)
          for (int ad = 0; ad < 2; ad++) begin
            k_lat = lt * 2; k_ack = ad * 5; k_phy = ad * 7; k_rdy = 3; k_stuck = 0;
            launch(p, pe[0]);
            finish_wait(gap);
            check(done && !error, "R6", "done", {30'b0, done, error}, 32'h2);
            check(!gap, "R3", "busy continuous", {31'b0, gap}, 32'h0);
            exp_writes(p, pe[0]);
            if (pe == 0)
              check(n_stat_rd == 0, "R8", "no ready poll", 32'(n_stat_rd), 32'h0);
            else
              check(n_stat_rd >= 1, "R6", "ready polled", 32'(n_stat_rd), 32'h1);
          end

    repeat (20) @(negedge clk);
    check(done && !error && !busy, "R9", "done held", {29'b0, done, error, busy}, 32'h4);

    // start while busy is ignored
    k_lat = 2; k_ack = 4; k_phy = 3; k_rdy = 3;
    launch(0, 1'b1);
    repeat (6) @(negedge clk);
    port_sel = 1'b1; perst_release = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait(gap);
    check(done, "R2", "run completes", {31'b0, done}, 32'h1);
    exp_writes(0, 1'b1);

    // timeouts
    k_lat = 0; k_ack = 0; k_phy = -1; k_rdy = 2; k_stuck = 0;
    timeout_case(1, 1'b1, 1, REF_TMO);
    check(lg_n == 1, "R7", "stops after clock wait", 32'(lg_n), 32'h1);
    k_phy = 0; k_ack = -1;
    timeout_case(0, 1'b0, 4, REF_TMO);
    k_ack = 0; k_stuck = 1;
    timeout_case(1, 1'b0, 6, REF_TMO);
    k_stuck = 0; k_rdy = -1;
    timeout_case(0, 1'b1, 11, RDY_TMO);

    repeat (30) @(negedge clk);
    check(error && err_step == 4'd11 && !done, "R9", "error held",
          {27'b0, error, done, err_step[2:0]}, 32'h13);

    k_rdy = 2;
    launch(1, 1'b1);
    check(!error, "R9", "start clears error", {31'b0, error}, 32'h0);
    finish_wait(gap);
    check(done && !error, "R6", "recovery run", {30'b0, done, error}, 32'h2);
    exp_writes(1, 1'b1);

    check(n_hold_err == 0, "R10", "request held until ack", 32'(n_hold_err), 32'h0);
    summary();
    $finish;
  end

endmodule